// File: doc/BRIEF.md
# Segmented Address Translation Front End

This block sits in front of a software-reloaded TLB. It keeps sixteen segment registers, picks one from the top nibble of each effective address, and works out the translation context for that request. The context covers the protection key, the no-execute and direct-store flags, the virtual segment identifier, the two page-group hash values, and the tag the TLB compares against. The TLB's hit and permission answer is folded back in the same cycle. Any request that cannot complete is classified, and its fault record is registered.

The fault record has everything a reload or fault handler needs: a fault class, an error code, a storage syndrome, the faulting address, the miss compare word and both hashes. The record is held until the handler acknowledges it. Direct-store segments are screened here only. Integer and cache-operation accesses go through, with cache operations flagged to use the effective address untranslated. Every other access kind gets its own fault code.

Top module: `segx_xlate_front`

## Requirements
- R1: Segment register number is ea[31:28]. Within a segment word, bit 31 is direct-store, bit 30 supervisor key, bit 29 user key, bit 28 no-execute, and bits 23:0 the VSID (ctx_vsid). A write on seg_we is visible from the next cycle on.
- R2: ctx_key is 1 when (user key and req_user) or (supervisor key and not req_user), and 0 otherwise.
- R3: The page index is ea[27:12]. ctx_hash1 is the VSID XOR the zero-extended page index, and ctx_hash2 is the bitwise complement of ctx_hash1.
- R4: ctx_tag is {VSID, 1'b0, page index[15:10]}. On a TLB miss, flt_cmp holds 0x80000000 ORed with that tag, and flt_hash1/flt_hash2 hold both hashes. For every other fault these three fields are 0.
- R5: A fetch (req_kind 0) from a non-direct-store segment with no-execute set gives class 4 and error code 0x10000000, whatever the TLB returns.
- R6: A TLB miss (tlb_hit 0) in a non-direct-store segment gives class 1 for fetch, 3 for store (req_kind 2) and 2 for load (req_kind 1 or 3). The error code has bit 18 set for fetch and bit 16 set for store, with the key at bit 19.
- R7: A hit with tlb_perm_ok 0 in a non-direct-store segment gives, for a fetch, class 4 with error code 0x08000000. For data it gives class 5 with error code 0, and syndrome 0x0A000000 on a store or 0x08000000 on a load.
- R8: In a direct-store segment the TLB inputs are ignored, and faults are raised as follows. A fetch gives class 4 with error code 0x10000000. Reservation ops (req_op 2) give class 5 with syndrome 0x06000000 on a store and 0x04000000 on a load. External-control ops (req_op 3) give 0x06100000 on a store and 0x04100000 on a load. Float ops (req_op 1) give class 6. req_op 5..7 give class 7.
- R9: In a direct-store segment an integer op (req_op 0) passes as a load only with key 0 and as a store only with key 1. Otherwise it gives class 5 with the R7 data syndromes. A cache op (req_op 4) passes with xl_bypass set.
- R10: xl_ok is high in the request cycle exactly when req_valid is high and no fault results. With req_valid low, nothing is recorded.
- R11: A fault is registered one cycle after its request, with flt_addr set to the address. The record holds against later faults until flt_ack clears it on the next edge. A fault arriving together with flt_ack is captured.
- R12: After reset all segment registers are zero and flt_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_we | input | 1 | Segment register write strobe |
| seg_wsel | input | 4 | Segment register to write |
| seg_wdata | input | 32 | Segment word to write |
| req_valid | input | 1 | Translation request present |
| req_ea | input | 32 | Effective address |
| req_user | input | 1 | Problem (user) state |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| req_op | input | 3 | 0 integer, 1 float, 2 reservation, 3 external, 4 cache |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_perm_ok | input | 1 | Matching entry grants the access |
| flt_ack | input | 1 | Handler releases the fault record |
| ctx_ds | output | 1 | Selected segment is direct-store |
| ctx_nx | output | 1 | Selected segment forbids execution |
| ctx_key | output | 1 | Effective protection key |
| ctx_vsid | output | 24 | Virtual segment identifier |
| ctx_hash1 | output | 24 | Primary hash |
| ctx_hash2 | output | 24 | Secondary hash |
| ctx_tag | output | 31 | Entry match tag |
| xl_ok | output | 1 | Request completes without fault |
| xl_bypass | output | 1 | Use effective address untranslated |
| flt_valid | output | 1 | Fault record held |
| flt_class | output | 3 | Fault class code |
| flt_err | output | 32 | Error code |
| flt_syn | output | 32 | Storage syndrome |
| flt_addr | output | 32 | Faulting address |
| flt_cmp | output | 32 | Miss compare word |
| flt_hash1 | output | 24 | Recorded primary hash |
| flt_hash2 | output | 24 | Recorded secondary hash |

## Verification
The hardest case to reach is a direct-store integer access that passes or faults depending on the key. It needs a segment word with chosen key bits, the right privilege state, and a load or store. The stimulus writes segments with every key pairing and walks both privilege states across them. The second hard case is a held record meeting a new fault, both with and without an acknowledge in the same cycle. Directed sequences leave a record standing, drive further faults at it, and then acknowledge on a faulting cycle. A long random phase follows, with acknowledges and segment rewrites mixed in, and a behavioural model is compared on every clock.

// File: rtl/segx_pkg.sv
package segx_pkg;
   localparam int WORD_W = 32;

   localparam logic [1:0] AK_FETCH = 2'd0;
   localparam logic [1:0] AK_STORE = 2'd2;

   localparam logic [2:0] OP_INT   = 3'd0;
   localparam logic [2:0] OP_FLOAT = 3'd1;
   localparam logic [2:0] OP_RESV  = 3'd2;
   localparam logic [2:0] OP_EXT   = 3'd3;
   localparam logic [2:0] OP_CACHE = 3'd4;

   typedef enum logic [2:0] {
      FC_NONE  = 3'd0,
      FC_IMISS = 3'd1,
      FC_LMISS = 3'd2,
      FC_SMISS = 3'd3,
      FC_ISTOR = 3'd4,
      FC_DSTOR = 3'd5,
      FC_ALIGN = 3'd6,
      FC_PROG  = 3'd7
   } fclass_e;

   localparam int KEY_BIT   = 19;
   localparam int IMISS_BIT = 18;
   localparam int SMISS_BIT = 16;

   localparam logic [WORD_W-1:0] ERR_NOEXEC = 32'h1000_0000;
   localparam logic [WORD_W-1:0] ERR_IPROT  = 32'h0800_0000;
   localparam logic [WORD_W-1:0] SYN_PROT_ST = 32'h0A00_0000;
   localparam logic [WORD_W-1:0] SYN_PROT_LD = 32'h0800_0000;
   localparam logic [WORD_W-1:0] SYN_RESV_ST = 32'h0600_0000;
   localparam logic [WORD_W-1:0] SYN_RESV_LD = 32'h0400_0000;
   localparam logic [WORD_W-1:0] SYN_EXT_ST  = 32'h0610_0000;
   localparam logic [WORD_W-1:0] SYN_EXT_LD  = 32'h0410_0000;

   typedef struct packed {
      fclass_e           cls;
      logic              miss;
      logic [WORD_W-1:0] err;
      logic [WORD_W-1:0] syn;
   } fdec_t;
endpackage

// File: rtl/segx_segfile.sv
module segx_segfile #(
   parameter int SEL_W = 4,
   parameter int SEG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SEL_W-1:0] wsel,
   input  logic [SEG_W-1:0] wdata,
   input  logic [SEL_W-1:0] rsel,
   output logic [SEG_W-1:0] rdata
);
   localparam int NSEG = 1 << SEL_W;

   if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
      $error("segx_segfile: SEL_W out of range");
   end

   logic [SEG_W-1:0] regs_q [NSEG];

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic [SEG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               q <= '0;
         else if (we && (wsel == SEL_W'(g)))       q <= wdata;
      end
      assign regs_q[g] = q;
   end

   assign rdata = regs_q[rsel];

   // R1: a write lands in the addressed register
   p_segwrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> regs_q[$past(wsel)] == $past(wdata));
endmodule

// File: rtl/segx_ctx.sv
module segx_ctx #(
   parameter int EA_W   = 32,
   parameter int SEL_W  = 4,
   parameter int PAGE_W = 12,
   parameter int VSID_W = 24,
   parameter int API_W  = 6,
   parameter int SEG_W  = 32
) (
   input  logic [SEG_W-1:0]          seg,
   input  logic [EA_W-1:0]           ea,
   input  logic                      user,
   output logic                      ds,
   output logic                      nx,
   output logic                      key,
   output logic [VSID_W-1:0]         vsid,
   output logic [VSID_W-1:0]         hash1,
   output logic [VSID_W-1:0]         hash2,
   output logic [VSID_W+API_W:0]     tag
);
   localparam int PIDX_W = EA_W - SEL_W - PAGE_W;
   localparam int FLAG_LO = SEG_W - 4;

   if (PIDX_W < API_W || VSID_W < PIDX_W || VSID_W >= FLAG_LO) begin : g_bad_geom
      $error("segx_ctx: inconsistent field widths");
   end

   logic [PIDX_W-1:0] pidx;
   logic              ks, kp;

   assign ds   = seg[SEG_W-1];
   assign ks   = seg[SEG_W-2];
   assign kp   = seg[SEG_W-3];
   assign nx   = seg[SEG_W-4];
   assign vsid = seg[VSID_W-1:0];
   assign key  = (kp & user) | (ks & ~user);
   assign pidx = ea[EA_W-SEL_W-1:PAGE_W];

   if (VSID_W > PIDX_W) begin : g_hash_pad
      assign hash1 = vsid ^ {{(VSID_W-PIDX_W){1'b0}}, pidx};
   end else begin : g_hash_flat
      assign hash1 = vsid ^ pidx;
   end
   assign hash2 = ~hash1;
   assign tag   = {vsid, 1'b0, pidx[PIDX_W-1 -: API_W]};

   logic unused_bits;
   assign unused_bits = ^{seg[FLAG_LO-1:VSID_W], ea[PAGE_W-1:0]};
endmodule

// File: rtl/segx_classify.sv
module segx_classify
   import segx_pkg::*;
(
   input  logic        valid,
   input  logic [1:0]  kind,
   input  logic [2:0]  op,
   input  logic        ds,
   input  logic        nx,
   input  logic        key,
   input  logic        tlb_hit,
   input  logic        tlb_perm_ok,
   output fdec_t       dec,
   output logic        fault,
   output logic        ok,
   output logic        bypass
);
   logic is_fetch, is_store;
   assign is_fetch = (kind == AK_FETCH);
   assign is_store = (kind == AK_STORE);

   always_comb begin
      dec = '{cls: FC_NONE, miss: 1'b0, err: '0, syn: '0};
      if (valid) begin
         if (!ds) begin
            if (is_fetch && nx) begin
               dec.cls = FC_ISTOR;
               dec.err = ERR_NOEXEC;
            end else if (!tlb_hit) begin
               dec.miss = 1'b1;
               dec.cls  = is_fetch ? FC_IMISS : (is_store ? FC_SMISS : FC_LMISS);
               dec.err[KEY_BIT]   = key;
               dec.err[IMISS_BIT] = is_fetch;
               dec.err[SMISS_BIT] = is_store;
            end else if (!tlb_perm_ok) begin
               if (is_fetch) begin
                  dec.cls = FC_ISTOR;
                  dec.err = ERR_IPROT;
               end else begin
                  dec.cls = FC_DSTOR;
                  dec.syn = is_store ? SYN_PROT_ST : SYN_PROT_LD;
               end
            end
         end else if (is_fetch) begin
            dec.cls = FC_ISTOR;
            dec.err = ERR_NOEXEC;
         end else begin
            unique case (op)
               OP_INT: begin
                  if (is_store ? !key : key) begin
                     dec.cls = FC_DSTOR;
                     dec.syn = is_store ? SYN_PROT_ST : SYN_PROT_LD;
                  end
               end
               OP_CACHE: ;
               OP_FLOAT: dec.cls = FC_ALIGN;
               OP_RESV: begin
                  dec.cls = FC_DSTOR;
                  dec.syn = is_store ? SYN_RESV_ST : SYN_RESV_LD;
               end
               OP_EXT: begin
                  dec.cls = FC_DSTOR;
                  dec.syn = is_store ? SYN_EXT_ST : SYN_EXT_LD;
               end
               default: dec.cls = FC_PROG;
            endcase
         end
      end
   end

   assign fault  = (dec.cls != FC_NONE);
   assign ok     = valid && !fault;
   assign bypass = valid && ds && !is_fetch && (op == OP_CACHE);
endmodule

// File: rtl/segx_faultrec.sv
module segx_faultrec
   import segx_pkg::*;
#(
   parameter int EA_W       = 32,
   parameter int HASH_W     = 24,
   parameter int TAG_W      = 31,
   parameter bit HOLD_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault,
   input  fdec_t             dec,
   input  logic [EA_W-1:0]   ea,
   input  logic [TAG_W-1:0]  tag,
   input  logic [HASH_W-1:0] hash1,
   input  logic [HASH_W-1:0] hash2,
   input  logic              ack,
   output logic              valid,
   output logic [2:0]        cls,
   output logic [WORD_W-1:0] err,
   output logic [WORD_W-1:0] syn,
   output logic [EA_W-1:0]   addr,
   output logic [WORD_W-1:0] cmp,
   output logic [HASH_W-1:0] h1,
   output logic [HASH_W-1:0] h2
);
   if (TAG_W + 1 != WORD_W) begin : g_bad_tag
      $error("segx_faultrec: tag plus marker must fill one word");
   end

   logic capture;

   if (HOLD_FIRST) begin : g_hold_oldest
      assign capture = fault && (!valid || ack);
   end else begin : g_keep_newest
      assign capture = fault;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         cls   <= '0;
         err   <= '0;
         syn   <= '0;
         addr  <= '0;
         cmp   <= '0;
         h1    <= '0;
         h2    <= '0;
      end else if (capture) begin
         valid <= 1'b1;
         cls   <= dec.cls;
         err   <= dec.err;
         syn   <= dec.syn;
         addr  <= ea;
         cmp   <= dec.miss ? {1'b1, tag} : '0;
         h1    <= dec.miss ? hash1 : '0;
         h2    <= dec.miss ? hash2 : '0;
      end else if (ack) begin
         valid <= 1'b0;
      end
   end

   // R11: a new fault with no record standing is captured
   p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fault && !valid |=> valid && addr == $past(ea));

   // R11: acknowledge without a new fault releases the record
   p_ack_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      valid && ack && !fault |=> !valid);

   if (HOLD_FIRST) begin : g_hold_chk
      // R11: an unacknowledged record stays put
      p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
         valid && !ack |=> valid && $stable(addr) && $stable(err) && $stable(cls));
   end

   // R4: compare word marker present exactly for miss classes
   p_cmp_marker_r4: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (cmp[WORD_W-1] == (cls inside {3'd1, 3'd2, 3'd3})));
endmodule

// File: rtl/segx_xlate_front.sv
module segx_xlate_front
   import segx_pkg::*;
#(
   parameter int EA_W       = 32,
   parameter int SEL_W      = 4,
   parameter int PAGE_W     = 12,
   parameter int VSID_W     = 24,
   parameter int API_W      = 6,
   parameter bit HOLD_FIRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  seg_we,
   input  logic [SEL_W-1:0]      seg_wsel,
   input  logic [WORD_W-1:0]     seg_wdata,
   input  logic                  req_valid,
   input  logic [EA_W-1:0]       req_ea,
   input  logic                  req_user,
   input  logic [1:0]            req_kind,
   input  logic [2:0]            req_op,
   input  logic                  tlb_hit,
   input  logic                  tlb_perm_ok,
   input  logic                  flt_ack,
   output logic                  ctx_ds,
   output logic                  ctx_nx,
   output logic                  ctx_key,
   output logic [VSID_W-1:0]     ctx_vsid,
   output logic [VSID_W-1:0]     ctx_hash1,
   output logic [VSID_W-1:0]     ctx_hash2,
   output logic [VSID_W+API_W:0] ctx_tag,
   output logic                  xl_ok,
   output logic                  xl_bypass,
   output logic                  flt_valid,
   output logic [2:0]            flt_class,
   output logic [WORD_W-1:0]     flt_err,
   output logic [WORD_W-1:0]     flt_syn,
   output logic [EA_W-1:0]       flt_addr,
   output logic [WORD_W-1:0]     flt_cmp,
   output logic [VSID_W-1:0]     flt_hash1,
   output logic [VSID_W-1:0]     flt_hash2
);
   localparam int TAG_W = VSID_W + API_W + 1;

   if (EA_W != WORD_W) begin : g_bad_ea
      $error("segx_xlate_front: address width must match word width");
   end

   logic [WORD_W-1:0] seg_word;
   fdec_t             dec;
   logic              fault;

   segx_segfile #(.SEL_W(SEL_W), .SEG_W(WORD_W)) u_segs (
      .clk(clk), .rst_n(rst_n), .we(seg_we), .wsel(seg_wsel), .wdata(seg_wdata),
      .rsel(req_ea[EA_W-1 -: SEL_W]), .rdata(seg_word));

   segx_ctx #(.EA_W(EA_W), .SEL_W(SEL_W), .PAGE_W(PAGE_W), .VSID_W(VSID_W),
              .API_W(API_W), .SEG_W(WORD_W)) u_ctx (
      .seg(seg_word), .ea(req_ea), .user(req_user), .ds(ctx_ds), .nx(ctx_nx),
      .key(ctx_key), .vsid(ctx_vsid), .hash1(ctx_hash1), .hash2(ctx_hash2),
      .tag(ctx_tag));

   segx_classify u_cls (
      .valid(req_valid), .kind(req_kind), .op(req_op), .ds(ctx_ds), .nx(ctx_nx),
      .key(ctx_key), .tlb_hit(tlb_hit), .tlb_perm_ok(tlb_perm_ok),
      .dec(dec), .fault(fault), .ok(xl_ok), .bypass(xl_bypass));

   segx_faultrec #(.EA_W(EA_W), .HASH_W(VSID_W), .TAG_W(TAG_W),
                   .HOLD_FIRST(HOLD_FIRST)) u_rec (
      .clk(clk), .rst_n(rst_n), .fault(fault), .dec(dec), .ea(req_ea),
      .tag(ctx_tag), .hash1(ctx_hash1), .hash2(ctx_hash2), .ack(flt_ack),
      .valid(flt_valid), .cls(flt_class), .err(flt_err), .syn(flt_syn),
      .addr(flt_addr), .cmp(flt_cmp), .h1(flt_hash1), .h2(flt_hash2));

   // R10: a completed request never leaves a new record when none was held
   p_ok_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      xl_ok && !flt_valid |=> !flt_valid);

   // R9: bypass only for passing direct-store requests
   p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xl_bypass |-> ctx_ds && xl_ok);

   // R5: no-execute fetch in a translated segment never completes
   p_nx_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == AK_FETCH && ctx_nx |-> !xl_ok);
endmodule

// File: tb/tb_segx_xlate_front.sv
module tb_segx_xlate_front;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        seg_we = 0;
   logic [3:0]  seg_wsel = 0;
   logic [31:0] seg_wdata = 0;
   logic        req_valid = 0;
   logic [31:0] req_ea = 0;
   logic        req_user = 0;
   logic [1:0]  req_kind = 0;
   logic [2:0]  req_op = 0;
   logic        tlb_hit = 0, tlb_perm_ok = 0, flt_ack = 0;
   logic        ctx_ds, ctx_nx, ctx_key, xl_ok, xl_bypass, flt_valid;
   logic [23:0] ctx_vsid, ctx_hash1, ctx_hash2, flt_hash1, flt_hash2;
   logic [30:0] ctx_tag;
   logic [2:0]  flt_class;
   logic [31:0] flt_err, flt_syn, flt_addr, flt_cmp;

   segx_xlate_front dut (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // behavioural reference state
   logic [31:0] m_seg [16];
   bit          m_v;
   int          m_cls;
   logic [31:0] m_err, m_syn, m_addr, m_cmp;
   logic [23:0] m_h1, m_h2;
   string       m_req;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cycle(bit we, logic [3:0] ws, logic [31:0] wd, bit v,
                        logic [31:0] ea, bit u, logic [1:0] k, logic [2:0] op,
                        bit hit, bit pok, bit ack);
      logic [31:0] s;
      bit ds, nx, key, st, ft, flt, byp, miss;
      logic [23:0] vs, h1;
      logic [15:0] pg;
      logic [30:0] tg;
      int cls;
      logic [31:0] err, syn;
      string rq;
      @(negedge clk);
      seg_we = we; seg_wsel = ws; seg_wdata = wd; req_valid = v; req_ea = ea;
      req_user = u; req_kind = k; req_op = op; tlb_hit = hit; tlb_perm_ok = pok;
      flt_ack = ack;
      #1;
      s  = m_seg[ea[31:28]];
      ds = s[31]; nx = s[28]; vs = s[23:0];
      key = (s[29] && u) || (s[30] && !u);
      pg = ea[27:12];
      h1 = vs ^ {8'h00, pg};
      tg = {vs, 1'b0, pg[15:10]};
      ft = (k == 2'd0); st = (k == 2'd2);
      cls = 0; err = 0; syn = 0; miss = 0; rq = "R10";
      if (v && !ds) begin
         if (ft && nx) begin cls = 4; err = 32'h1000_0000; rq = "R5"; end
         else if (!hit) begin
            miss = 1; rq = "R6";
            cls = ft ? 1 : (st ? 3 : 2);
            err = (key ? 32'h0008_0000 : 0) | (ft ? 32'h0004_0000 : 0) | (st ? 32'h0001_0000 : 0);
         end else if (!pok) begin
            rq = "R7";
            if (ft) begin cls = 4; err = 32'h0800_0000; end
            else begin cls = 5; syn = st ? 32'h0A00_0000 : 32'h0800_0000; end
         end
      end else if (v) begin
         rq = "R8";
         if (ft) begin cls = 4; err = 32'h1000_0000; end
         else if (op == 0) begin
            rq = "R9";
            if ((st && !key) || (!st && key)) begin
               cls = 5; syn = st ? 32'h0A00_0000 : 32'h0800_0000;
            end
         end else if (op == 1) cls = 6;
         else if (op == 2) begin cls = 5; syn = st ? 32'h0600_0000 : 32'h0400_0000; end
         else if (op == 3) begin cls = 5; syn = st ? 32'h0610_0000 : 32'h0410_0000; end
         else if (op == 4) rq = "R9";
         else cls = 7;
      end
      flt = (cls != 0);
      byp = v && ds && !ft && (op == 4);
      chk("R1", {ctx_ds, ctx_nx, ctx_vsid}, {ds, nx, vs}, "segment fields");
      chk("R2", ctx_key, key, "key");
      chk("R3", {ctx_hash1, ctx_hash2}, {h1, ~h1}, "hashes");
      chk("R4", ctx_tag, tg, "tag");
      chk(rq, xl_ok, v && !flt, "xl_ok");
      chk("R9", xl_bypass, byp, "xl_bypass");
      @(posedge clk);
      #1;
      if (we) m_seg[ws] = wd;
      if (flt && (!m_v || ack)) begin
         m_v = 1; m_cls = cls; m_err = err; m_syn = syn; m_addr = ea; m_req = rq;
         m_cmp = miss ? {1'b1, tg} : 0;
         m_h1 = miss ? h1 : 0; m_h2 = miss ? ~h1 : 0;
      end else if (ack) m_v = 0;
      chk("R11", flt_valid, m_v, "flt_valid");
      if (m_v) begin
         chk(m_req, flt_class, m_cls, "class");
         chk(m_req, flt_err, m_err, "error code");
         chk(m_req, flt_syn, m_syn, "syndrome");
         chk("R11", flt_addr, m_addr, "address");
         chk("R4", {flt_cmp, flt_hash1, flt_hash2}, {m_cmp, m_h1, m_h2}, "miss words");
      end
   endtask

   task automatic wseg(logic [3:0] i, logic [31:0] d);
      cycle(1, i, d, 0, 0, 0, 1, 0, 1, 1, 0);
   endtask

   task automatic req(logic [31:0] ea, bit u, logic [1:0] k, logic [2:0] op,
                      bit hit, bit pok, bit ack);
      cycle(0, 0, 0, 1, ea, u, k, op, hit, pok, ack);
   endtask

   task automatic run_all();
      for (int i = 0; i < 16; i++) m_seg[i] = 0;
      m_v = 0; m_cls = 0; m_err = 0; m_syn = 0; m_addr = 0; m_cmp = 0;
      m_h1 = 0; m_h2 = 0; m_req = "R12";
      repeat (3) @(posedge clk);
      #1;
      chk("R12", flt_valid, 0, "reset record");
      chk("R12", {ctx_ds, ctx_nx, ctx_key, ctx_vsid}, 0, "reset segment");
      rst_n = 1;
      // R1 R2: segments with assorted keys and flags
      wseg(4'h1, 32'h4012_3456);
      wseg(4'h2, 32'h3000_00FF);
      wseg(4'h3, 32'hA000_0001);
      wseg(4'h4, 32'hC000_0002);
      wseg(4'h5, 32'hF0AB_CDEF);
      // R6: misses for all kinds, key both ways
      req(32'h1ABC_D123, 0, 0, 0, 0, 0, 0);
      req(32'h1000_0000, 0, 1, 0, 0, 0, 1);
      req(32'h1FFF_F000, 1, 2, 0, 0, 0, 1);
      req(32'h2345_6000, 1, 1, 0, 0, 0, 1);
      // R5: nx fetch despite hit
      req(32'h2000_1000, 0, 0, 0, 1, 1, 1);
      // R7: protection
      req(32'h1000_2000, 0, 0, 0, 1, 0, 1);
      req(32'h1000_2000, 0, 2, 0, 1, 0, 1);
      req(32'h1000_2000, 0, 1, 0, 1, 0, 1);
      req(32'h1000_2000, 0, 3, 0, 1, 0, 1);
      // R10: clean hit, then idle request
      req(32'h1000_3000, 0, 1, 0, 1, 1, 1);
      cycle(0, 0, 0, 0, 32'h1000_0000, 0, 0, 0, 0, 0, 0);
      // R8 R9: direct-store segment 3 (user key) and 4 (supervisor key)
      for (int sg = 3; sg <= 4; sg++)
         for (int u = 0; u < 2; u++)
            for (int k = 0; k < 4; k++)
               for (int op = 0; op < 8; op++)
                  req({sg[3:0], 28'h0123_456}, u[0], k[1:0], op[2:0], 0, 0, 1);
      // R11: hold against later faults, then ack with simultaneous fault
      req(32'h1111_1000, 0, 1, 0, 0, 0, 1);
      req(32'h1222_2000, 0, 2, 0, 0, 0, 0);
      req(32'h2000_0000, 0, 0, 0, 1, 1, 0);
      req(32'h1333_3000, 0, 0, 0, 0, 0, 1);
      cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      // R1: write and read same segment in one cycle
      cycle(1, 4'h6, 32'h0055_5555, 1, 32'h6000_0000, 0, 1, 0, 1, 1, 0);
      req(32'h6000_0000, 0, 1, 0, 1, 1, 0);
      // random phase
      for (int n = 0; n < 3000; n++) begin
         bit we_r;
         we_r = ($urandom_range(0, 15) == 0);
         cycle(we_r, 4'($urandom), $urandom, $urandom_range(0, 3) != 0, $urandom,
               1'($urandom), 2'($urandom), 3'($urandom), 1'($urandom),
               1'($urandom), $urandom_range(0, 2) == 0);
      end
      done = 1;
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (200000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule